// File: doc/BRIEF.md
# Integer ALU with Registered Status Flags

This block is a single-cycle integer arithmetic and logic unit. The result is computed combinationally from an operation code, a width select and two operands. Alongside it sits a 32-bit status word held in a register. The status word records signed overflow, sign, zero and unsigned carry/borrow. Each operation decides which of those four bits it rewrites, and the word is written only on a clock edge where the write enable is high.

The unit supports add, subtract, compare, increment, decrement, negate, AND, OR, XOR, test and NOT. Every operation has a full 32-bit form and an 8-bit form. In the 8-bit form, only the low byte of each operand is used and the flags are derived from that byte. Compare and test exist only for their effect on the flags, so their result output reads zero. Increment and decrement keep the stored carry. NOT changes no flag at all.

Top module: `flag_alu`

## Requirements
- R1: After reset the status word is zero. Overflow sits at bit 11, sign at bit 7, zero at bit 6 and carry at bit 0. Every other bit of the word stays zero on every write.
- R2: The `result` output is combinational from the inputs. The status word changes only on a rising clock edge with `wrEn` high, and it holds its value whenever `wrEn` is low.
- R3: Code 0 (add) gives `opA+opB`. Carry is the unsigned carry out. Overflow is set when both operands have the same sign and the sum has the other sign. Sign and zero come from the sum.
- R4: Code 1 (subtract) gives `opA-opB`. Carry is set on unsigned borrow (opA < opB). Overflow is set when the operand signs differ and the difference's sign differs from opA's. Sign and zero come from the difference.
- R5: Code 2 (compare) writes the same four flags as subtract, and its result output is zero.
- R6: Codes 3 (increment) and 4 (decrement) give `opA+1` and `opA-1`. They update overflow, sign and zero, and they leave carry at its stored value.
- R7: Code 5 (negate) gives `0-opA`. Carry is set exactly when opA is nonzero. Overflow is set exactly when opA is the most negative value. Sign and zero come from the result.
- R8: Codes 6 (AND), 7 (OR) and 8 (XOR) give the bitwise result of opA and opB. They clear overflow and carry, and they set sign and zero from the result.
- R9: Code 9 (test) writes the same flags as AND, and its result output is zero.
- R10: Code 10 (NOT) gives the bitwise inverse of opA and leaves all four flags unchanged.
- R11: With `byteMode` high, only opA[7:0] and opB[7:0] are used and result[31:8] is zero. Carry is taken out of bit 7, sign is bit 7 of the result, overflow uses 8-bit signed ranges, and zero tests the low byte only.
- R12: Codes 11 to 15 give a zero result and leave the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the status register |
| rstN | input | 1 | Asynchronous active-low reset |
| opCode | input | 4 | Operation select (codes in R3 to R12) |
| byteMode | input | 1 | 1 selects the 8-bit form |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| wrEn | input | 1 | Commit the flag update on this edge |
| result | output | 32 | Combinational result |
| flags | output | 32 | Registered status word |

## Verification
The bench targets the edges of the signed and unsigned ranges in both widths. At those points, a design that derived overflow from the carry out would report the wrong flag for 0x7FFFFFFF+1 or 0x80-1. The bench also checks that increment and decrement run through with a carry left set beforehand, because a design that rewrote carry there would lose the stored borrow. Negate of zero and of the most negative value is checked to catch inverted carry and missing overflow. Byte-mode cases with large upper operand bits would expose a design that let bits 31:8 leak into the result, the zero test or the carry.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int FLAG_CF = 0;
  localparam int FLAG_ZF = 6;
  localparam int FLAG_SF = 7;
  localparam int FLAG_OF = 11;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_INC  = 4'd3,
    OP_DEC  = 4'd4,
    OP_NEG  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_TEST = 4'd9,
    OP_NOT  = 4'd10
  } aluOp_e;

  typedef enum logic [2:0] {
    Y_B,
    Y_NOT_B,
    Y_ZERO,
    Y_ONES,
    Y_NOT_A
  } ySel_e;

  typedef enum logic [1:0] {
    L_AND,
    L_OR,
    L_XOR,
    L_NOT
  } logicSel_e;

  typedef struct packed {
    logic      xIsZero;
    ySel_e     ySel;
    logic      carryIn;
    logic      useLogic;
    logicSel_e logicSel;
    logic      keepResult;
    logic      borrowCarry;
    logic      wrCarry;
    logic      wrOvf;
    logic      wrSignZero;
  } aluStrb_t;

endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic [3:0] opCode,
  output aluStrb_t   strb
);

  always_comb begin
    strb = '{xIsZero: 1'b0, ySel: Y_B, carryIn: 1'b0, useLogic: 1'b0,
             logicSel: L_AND, keepResult: 1'b0, borrowCarry: 1'b0,
             wrCarry: 1'b0, wrOvf: 1'b0, wrSignZero: 1'b0};
    case (opCode)
      OP_ADD: begin
        strb.keepResult = 1'b1;
        strb.wrCarry    = 1'b1;
        strb.wrOvf      = 1'b1;
        strb.wrSignZero = 1'b1;
      end
      OP_SUB, OP_CMP: begin
        strb.ySel        = Y_NOT_B;
        strb.carryIn     = 1'b1;
        strb.borrowCarry = 1'b1;
        strb.keepResult  = (opCode == OP_SUB);
        strb.wrCarry     = 1'b1;
        strb.wrOvf       = 1'b1;
        strb.wrSignZero  = 1'b1;
      end
      OP_INC: begin
        strb.ySel       = Y_ZERO;
        strb.carryIn    = 1'b1;
        strb.keepResult = 1'b1;
        strb.wrOvf      = 1'b1;
        strb.wrSignZero = 1'b1;
      end
      OP_DEC: begin
        strb.ySel       = Y_ONES;
        strb.keepResult = 1'b1;
        strb.wrOvf      = 1'b1;
        strb.wrSignZero = 1'b1;
      end
      OP_NEG: begin
        strb.xIsZero     = 1'b1;
        strb.ySel        = Y_NOT_A;
        strb.carryIn     = 1'b1;
        strb.borrowCarry = 1'b1;
        strb.keepResult  = 1'b1;
        strb.wrCarry     = 1'b1;
        strb.wrOvf       = 1'b1;
        strb.wrSignZero  = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_TEST: begin
        strb.useLogic   = 1'b1;
        strb.logicSel   = (opCode == OP_OR)  ? L_OR :
                          (opCode == OP_XOR) ? L_XOR : L_AND;
        strb.keepResult = (opCode != OP_TEST);
        strb.wrCarry    = 1'b1;
        strb.wrOvf      = 1'b1;
        strb.wrSignZero = 1'b1;
      end
      OP_NOT: begin
        strb.useLogic   = 1'b1;
        strb.logicSel   = L_NOT;
        strb.keepResult = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flag_alu_dp.sv
module flag_alu_dp
  import flag_alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int NW = 8
) (
  input  aluStrb_t       strb,
  input  logic           byteMode,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  output logic [W-1:0]   result,
  output logic           candCarry,
  output logic           candOvf,
  output logic           candSign,
  output logic           candZero
);

  localparam logic [W-1:0] NARROW_MASK = {{(W-NW){1'b0}}, {NW{1'b1}}};

  logic [W-1:0] laneMask;
  logic [W-1:0] aM, bM, xOp, yOp, sumR, logicR, rawR;
  logic [W:0]   sumFull;
  logic         carryOut, sx, sy, sr;

  function automatic logic topBit(input logic [W-1:0] v, input logic narrow);
    return narrow ? v[NW-1] : v[W-1];
  endfunction

  always_comb begin
    laneMask = byteMode ? NARROW_MASK : '1;
    aM = opA & laneMask;
    bM = opB & laneMask;
    xOp = strb.xIsZero ? '0 : aM;
    case (strb.ySel)
      Y_NOT_B: yOp = ~bM & laneMask;
      Y_ZERO:  yOp = '0;
      Y_ONES:  yOp = laneMask;
      Y_NOT_A: yOp = ~aM & laneMask;
      default: yOp = bM;
    endcase
    sumFull  = {1'b0, xOp} + {1'b0, yOp} + {{W{1'b0}}, strb.carryIn};
    sumR     = sumFull[W-1:0] & laneMask;
    carryOut = byteMode ? sumFull[NW] : sumFull[W];
    case (strb.logicSel)
      L_OR:    logicR = aM | bM;
      L_XOR:   logicR = aM ^ bM;
      L_NOT:   logicR = ~aM & laneMask;
      default: logicR = aM & bM;
    endcase
    rawR   = strb.useLogic ? logicR : sumR;
    result = strb.keepResult ? rawR : '0;
    sx = topBit(xOp, byteMode);
    sy = topBit(yOp, byteMode);
    sr = topBit(sumR, byteMode);
    candSign  = topBit(rawR, byteMode);
    candZero  = (rawR == '0);
    candCarry = strb.useLogic ? 1'b0 : (strb.borrowCarry ? ~carryOut : carryOut);
    candOvf   = strb.useLogic ? 1'b0 : ((sx == sy) && (sr != sx));
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 8,
  parameter int FLAG_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        opCode,
  input  logic              byteMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              wrEn,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);

  localparam logic [FLAG_W-1:0] LIVE_MASK =
    (FLAG_W'(1) << FLAG_OF) | (FLAG_W'(1) << FLAG_SF) |
    (FLAG_W'(1) << FLAG_ZF) | (FLAG_W'(1) << FLAG_CF);

  aluStrb_t          strb;
  logic              candCarry, candOvf, candSign, candZero;
  logic [FLAG_W-1:0] flagsQ;

  flag_alu_ctrl u_ctrl (
    .opCode (opCode),
    .strb   (strb)
  );

  flag_alu_dp #(.W(DATA_W), .NW(NARROW_W)) u_dp (
    .strb      (strb),
    .byteMode  (byteMode),
    .opA       (opA),
    .opB       (opB),
    .result    (result),
    .candCarry (candCarry),
    .candOvf   (candOvf),
    .candSign  (candSign),
    .candZero  (candZero)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
    end else if (wrEn) begin
      if (strb.wrCarry)    flagsQ[FLAG_CF] <= candCarry;
      if (strb.wrOvf)      flagsQ[FLAG_OF] <= candOvf;
      if (strb.wrSignZero) begin
        flagsQ[FLAG_SF] <= candSign;
        flagsQ[FLAG_ZF] <= candZero;
      end
    end
  end

  assign flags = flagsQ;

  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (flagsQ & ~LIVE_MASK) == '0); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(flagsQ)); // R2

  AST_CMP_TEST_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_CMP || opCode == OP_TEST) |-> result == '0); // R5 R9

  AST_STEP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (opCode == OP_INC || opCode == OP_DEC)) |=>
      flagsQ[FLAG_CF] == $past(flagsQ[FLAG_CF])); // R6

  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (opCode == OP_AND || opCode == OP_OR || opCode == OP_XOR ||
              opCode == OP_TEST)) |=> (!flagsQ[FLAG_OF] && !flagsQ[FLAG_CF])); // R8

  AST_NOT_NO_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opCode == OP_NOT) |=> $stable(flagsQ)); // R10

  AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    byteMode |-> result[DATA_W-1:NARROW_W] == '0); // R11

  AST_UNUSED_CODE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opCode > 4'd10) |=> $stable(flagsQ)); // R12

endmodule

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opCode = '0;
  logic        byteMode = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        wrEn = 1'b0;
  logic [31:0] result;
  logic [31:0] flags;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [31:0] expFlags = '0;
  string prevTag = "R1";

  always #4 clk = ~clk;

  flag_alu u_dut (
    .clk(clk), .rstN(rstN), .opCode(opCode), .byteMode(byteMode),
    .opA(opA), .opB(opB), .wrEn(wrEn), .result(result), .flags(flags)
  );

  function automatic string tagOf(input logic [3:0] op, input logic bm);
    if (bm && op <= 4'd10) return "R11";
    case (op)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3, 4'd4: return "R6";
      4'd5: return "R7";
      4'd6, 4'd7, 4'd8: return "R8";
      4'd9: return "R9";
      4'd10: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic refOp(input logic [3:0] op, input logic bm,
                       input logic [31:0] a0, input logic [31:0] b0,
                       input logic [31:0] fin,
                       output logic [31:0] res, output logic [31:0] fout);
    longint unsigned w, mask, half, a, b, r;
    bit c, o, wc, wo, wsz, keep;
    w = bm ? 8 : 32;
    mask = (64'd1 << w) - 1;
    half = 64'd1 << (w - 1);
    a = a0 & mask;
    b = b0 & mask;
    r = 0; c = 0; o = 0; wc = 0; wo = 0; wsz = 0; keep = 1;
    case (op)
      4'd0: begin
        r = (a + b) & mask; c = ((a + b) >> w) != 0;
        o = ((a & half) == (b & half)) && ((r & half) != (a & half));
        wc = 1; wo = 1; wsz = 1;
      end
      4'd1, 4'd2: begin
        r = (a - b) & mask; c = a < b;
        o = ((a & half) != (b & half)) && ((r & half) != (a & half));
        wc = 1; wo = 1; wsz = 1; keep = (op == 4'd1);
      end
      4'd3: begin r = (a + 1) & mask; o = (a == half - 1); wo = 1; wsz = 1; end
      4'd4: begin r = (a - 1) & mask; o = (a == half); wo = 1; wsz = 1; end
      4'd5: begin
        r = (0 - a) & mask; c = (a != 0); o = (a == half);
        wc = 1; wo = 1; wsz = 1;
      end
      4'd6, 4'd9: begin r = a & b; wc = 1; wo = 1; wsz = 1; keep = (op == 4'd6); end
      4'd7: begin r = a | b; wc = 1; wo = 1; wsz = 1; end
      4'd8: begin r = a ^ b; wc = 1; wo = 1; wsz = 1; end
      4'd10: r = (~a) & mask;
      default: keep = 0;
    endcase
    fout = fin;
    if (wc) fout[0] = c;
    if (wo) fout[11] = o;
    if (wsz) begin
      fout[7] = (r & half) != 0;
      fout[6] = (r == 0);
    end
    res = keep ? r[31:0] : 32'd0;
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic bm,
                      input logic [31:0] a, input logic [31:0] b, input logic we);
    logic [31:0] er, ef;
    @(negedge clk);
    opCode = op; byteMode = bm; opA = a; opB = b; wrEn = we;
    #1;
    check(prevTag, "flags", flags, expFlags);
    refOp(op, bm, a, b, expFlags, er, ef);
    check(tagOf(op, bm), "result", result, er);
    if (we) begin
      expFlags = ef;
      prevTag = tagOf(op, bm);
    end else begin
      prevTag = "R2";
    end
  endtask

  logic [31:0] edgeVals [8] = '{32'h0, 32'h1, 32'h7f, 32'h80, 32'hff,
                                32'h7fffffff, 32'h80000000, 32'hffffffff};

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset flags", flags, 32'h0);
    rstN = 1'b1;
    // carry set before inc/dec, then confirm they keep it (R6)
    step(4'd1, 1'b0, 32'h0, 32'h1, 1'b1);
    step(4'd3, 1'b0, 32'h7fffffff, 32'h0, 1'b1);
    step(4'd4, 1'b1, 32'hffffff80, 32'h0, 1'b1);
    step(4'd10, 1'b0, 32'h12345678, 32'h0, 1'b1); // R10
    step(4'd5, 1'b0, 32'h0, 32'h0, 1'b1);         // R7 neg of zero
    step(4'd5, 1'b0, 32'h80000000, 32'h0, 1'b1);  // R7 most negative
    step(4'd0, 1'b1, 32'hAB00007f, 32'hCD000001, 1'b1); // R11
    for (int op = 0; op < 16; op++)
      for (int bm = 0; bm < 2; bm++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            step(op[3:0], bm[0], edgeVals[i] ^ (bm[0] ? 32'h5a5a5a00 : 32'h0),
                 edgeVals[j], 1'b1);
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] a, b;
      a = ($urandom % 3 == 0) ? edgeVals[$urandom % 8] : $urandom;
      b = ($urandom % 3 == 0) ? edgeVals[$urandom % 8] : $urandom;
      step(4'($urandom % 16), 1'($urandom % 2), a, b, ($urandom % 4) != 0);
    end
    @(negedge clk);
    #1;
    check(prevTag, "flags", flags, expFlags);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule